// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the configuration store of an interrupt controller. For every implemented interrupt line it keeps an enable flag, a pending flag, a group flag, an 8-bit priority and an 8-bit CPU target mask. A small control word holds one forwarding enable for each of the two groups. Software reaches all of this through a 32-bit register bus with byte strobes. Writes take effect at the next rising clock edge. Read data is combinational from the bus address.

Enable and pending state are each reached through two addresses, one that sets bits and one that clears them, so one interrupt can be changed without a read-modify-write. Priorities are one byte per interrupt, four to a word. Target masks are packed four to a word as well. Interrupt inputs are latched as pending, either on a rising edge or while the level is high, chosen by a parameter. Enable, pending, group, priority and target state go out as flat vectors to the arbitration logic downstream. Bits for lines at or above the implemented count read as zero and cannot be written, so software can probe how many lines exist.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset, every enable, pending, group, priority and target value is zero, and so is the control word.
- R2: Writing the word at byte offset 0x100 + 4n sets the enable of interrupt 32n + b for each written bit b that is 1. A 0 bit leaves the enable unchanged. Reading offset 0x100 + 4n or 0x180 + 4n returns the current enables of that word.
- R3: Writing the word at offset 0x180 + 4n clears the enable of interrupt 32n + b for each written bit b that is 1. A 0 bit has no effect.
- R4: The word at offset 0x080 + 4n is a plain read/write group register. Bit b is the group of interrupt 32n + b (0 = group 0, 1 = group 1), and it drives the group output vector.
- R5: Writing a 1 at offset 0x200 + 4n sets the pending bit of interrupt 32n + b. Writing a 1 at offset 0x280 + 4n clears it. Reading either offset returns the pending bits.
- R6: In edge mode, a rising input sets that interrupt's pending bit at the first clock edge after the rise. A line held high does not set it again. If a clear-pending write lands in the same cycle as an edge, the edge wins.
- R7: The priority of interrupt i is the byte at offset 0x400 + i, which is byte lane i mod 4 of word 0x400 + 4*(i/4). A single-strobe write changes only that one priority.
- R8: The target mask of interrupt i is the byte at bits 8*(i mod 4) of the word at offset 0x800 + 4*(i/4). Byte strobes select which targets are written.
- R9: The control word at offset 0x000 holds bit 0 (group 0 forwarding enable) and bit 1 (group 1 forwarding enable). All its other bits read as zero.
- R10: Bits and bytes of interrupts numbered at or above NUM_IRQ are not writable and always read as zero.
- R11: Reads of unmapped offsets return zero. Writes to unmapped offsets change no state.
- R12: On a write to any bit register, only bytes whose strobe is 1 take effect. A write with no strobe set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write request for the current cycle |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_IRQ | Interrupt request inputs |
| en_o | output | NUM_IRQ | Per-interrupt enable |
| pend_o | output | NUM_IRQ | Per-interrupt pending |
| grp_o | output | NUM_IRQ | Per-interrupt group |
| prio_o | output | 8*NUM_IRQ | Priorities, interrupt i at bits 8i+7:8i |
| tgt_o | output | 8*NUM_IRQ | Target masks, interrupt i at bits 8i+7:8i |
| grp0_en_o | output | 1 | Group 0 forwarding enable |
| grp1_en_o | output | 1 | Group 1 forwarding enable |

## Verification
The hardest case to reach from the ports is a clear-pending write that lands in the same cycle as a new rising edge on the same line. The bench first sets that line's pending bit through the set alias. It then raises the input at the same falling edge at which it presents the clear write, so the following rising edge sees both. The implemented-count boundary is reached by building the bench with a count of 40, which is not a multiple of 32. One set-enable word is then only partly implemented and the next one is not implemented at all.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
   localparam int MAX_IRQ = 1020;
   localparam int BUS_W   = 32;
   localparam int ADDR_W  = 12;
   localparam int FIELD_W = 8;
   localparam int LANES   = BUS_W / FIELD_W;
   localparam int WADDR_W = ADDR_W - 2;
   localparam int PAD_W   = 1024;

   localparam logic [WADDR_W-1:0] PRIO_BASE_W = 10'h100;
   localparam logic [WADDR_W-1:0] TGT_BASE_W  = 10'h200;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_GROUP,
      SEL_SETEN,
      SEL_CLREN,
      SEL_SETPD,
      SEL_CLRPD,
      SEL_PRIO,
      SEL_TGT
   } reg_sel_t;

   function automatic reg_sel_t decode_word(input logic [WADDR_W-1:0] w);
      reg_sel_t s;
      s = SEL_NONE;
      case (w[9:8])
         2'd1: s = SEL_PRIO;
         2'd2: s = SEL_TGT;
         2'd0: begin
            case (w[7:5])
               3'd0: s = (w == '0) ? SEL_CTRL : SEL_NONE;
               3'd1: s = SEL_GROUP;
               3'd2: s = SEL_SETEN;
               3'd3: s = SEL_CLREN;
               3'd4: s = SEL_SETPD;
               3'd5: s = SEL_CLRPD;
               default: s = SEL_NONE;
            endcase
         end
         default: s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/irq_dist_trig.sv
module irq_dist_trig #(
   parameter int N           = 64,
   parameter bit LEVEL_SENSE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   output logic [N-1:0] hit
);
   generate
      if (LEVEL_SENSE) begin : g_level
         assign hit = irq_in;
      end else begin : g_edge
         logic [N-1:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= '0;
            else        irq_q <= irq_in;
         end
         assign hit = irq_in & ~irq_q;
      end
   endgenerate
endmodule

// File: rtl/irq_dist_bitbank.sv
module irq_dist_bitbank #(
   parameter int N = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   input  logic [N-1:0] hw_set,
   output logic [N-1:0] q
);
   // hardware set is applied last so it overrides a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_vec) | set_vec | hw_set;
   end
endmodule

// File: rtl/irq_dist_bytebank.sv
module irq_dist_bytebank
   import irq_dist_pkg::*;
#(
   parameter int                 N      = 64,
   parameter logic [WADDR_W-1:0] BASE_W = 10'h100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [WADDR_W-1:0]    waddr,
   input  logic [BUS_W-1:0]      wdata,
   input  logic [LANES-1:0]      strb,
   output logic [BUS_W-1:0]      rdata,
   output logic [N*FIELD_W-1:0]  q_flat
);
   localparam int NWORDS = (N + LANES - 1) / LANES;
   localparam int PADN   = NWORDS * LANES;

   logic [FIELD_W-1:0] mem [PADN];

   genvar gi;
   generate
      for (gi = 0; gi < PADN; gi++) begin : g_field
         localparam int                 LN = gi % LANES;
         localparam logic [WADDR_W-1:0] WA = BASE_W + WADDR_W'(gi / LANES);
         if (gi < N) begin : g_impl
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  mem[gi] <= '0;
               else if (wr && (waddr == WA) && strb[LN])
                  mem[gi] <= wdata[FIELD_W*LN +: FIELD_W];
            end
            assign q_flat[FIELD_W*gi +: FIELD_W] = mem[gi];
         end else begin : g_unimpl
            assign mem[gi] = '0;
         end
      end
   endgenerate

   // word index within the region, valid only when the word is implemented
   logic [WADDR_W-1:0] rel;
   always_comb begin
      rel   = waddr - BASE_W;
      rdata = '0;
      if ((waddr >= BASE_W) && (int'(rel) < NWORDS)) begin
         for (int l = 0; l < LANES; l++)
            rdata[FIELD_W*l +: FIELD_W] = mem[int'(rel) * LANES + l];
      end
   end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ     = 64,
   parameter bit LEVEL_SENSE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [BUS_W-1:0]         bus_wdata,
   input  logic [LANES-1:0]         bus_strb,
   output logic [BUS_W-1:0]         bus_rdata,
   input  logic [NUM_IRQ-1:0]       irq_in,
   output logic [NUM_IRQ-1:0]       en_o,
   output logic [NUM_IRQ-1:0]       pend_o,
   output logic [NUM_IRQ-1:0]       grp_o,
   output logic [NUM_IRQ*FIELD_W-1:0] prio_o,
   output logic [NUM_IRQ*FIELD_W-1:0] tgt_o,
   output logic                     grp0_en_o,
   output logic                     grp1_en_o
);
   generate
      if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_count
         $error("irq_dist_regs: NUM_IRQ must lie in 1..1020");
      end
   endgenerate

   logic [WADDR_W-1:0] waddr;
   reg_sel_t           sel;
   assign waddr = bus_addr[ADDR_W-1:2];
   assign sel   = decode_word(waddr);

   // per-line set/clear strobes for the bit registers
   logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, gp_set, gp_clr, hw_hit;
   logic [NUM_IRQ-1:0] zero_vec;
   assign zero_vec = '0;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
         localparam int BI = gi % BUS_W;
         localparam int WI = gi / BUS_W;
         logic hit_w, d;
         assign hit_w = bus_wr && (waddr[4:0] == 5'(WI)) && bus_strb[BI / FIELD_W];
         assign d     = bus_wdata[BI];
         assign en_set[gi] = hit_w && (sel == SEL_SETEN) && d;
         assign en_clr[gi] = hit_w && (sel == SEL_CLREN) && d;
         assign pd_set[gi] = hit_w && (sel == SEL_SETPD) && d;
         assign pd_clr[gi] = hit_w && (sel == SEL_CLRPD) && d;
         assign gp_set[gi] = hit_w && (sel == SEL_GROUP) && d;
         assign gp_clr[gi] = hit_w && (sel == SEL_GROUP) && !d;
      end
   endgenerate

   irq_dist_trig #(.N(NUM_IRQ), .LEVEL_SENSE(LEVEL_SENSE)) u_trig (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .hit(hw_hit));

   irq_dist_bitbank #(.N(NUM_IRQ)) u_enable (
      .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr),
      .hw_set(zero_vec), .q(en_o));

   irq_dist_bitbank #(.N(NUM_IRQ)) u_pending (
      .clk(clk), .rst_n(rst_n), .set_vec(pd_set), .clr_vec(pd_clr),
      .hw_set(hw_hit), .q(pend_o));

   irq_dist_bitbank #(.N(NUM_IRQ)) u_group (
      .clk(clk), .rst_n(rst_n), .set_vec(gp_set), .clr_vec(gp_clr),
      .hw_set(zero_vec), .q(grp_o));

   logic [BUS_W-1:0] prio_rd, tgt_rd;

   irq_dist_bytebank #(.N(NUM_IRQ), .BASE_W(PRIO_BASE_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .waddr(waddr),
      .wdata(bus_wdata), .strb(bus_strb), .rdata(prio_rd), .q_flat(prio_o));

   irq_dist_bytebank #(.N(NUM_IRQ), .BASE_W(TGT_BASE_W)) u_tgt (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .waddr(waddr),
      .wdata(bus_wdata), .strb(bus_strb), .rdata(tgt_rd), .q_flat(tgt_o));

   // control word: two forwarding enables in byte lane 0
   logic [1:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (bus_wr && (sel == SEL_CTRL) && bus_strb[0])
         ctrl_q <= bus_wdata[1:0];
   end
   assign grp0_en_o = ctrl_q[0];
   assign grp1_en_o = ctrl_q[1];

   // read path: bit registers are padded to the full 1024-line space
   logic [PAD_W-1:0] bit_src;
   always_comb begin
      case (sel)
         SEL_GROUP:            bit_src = PAD_W'(grp_o);
         SEL_SETEN, SEL_CLREN: bit_src = PAD_W'(en_o);
         SEL_SETPD, SEL_CLRPD: bit_src = PAD_W'(pend_o);
         default:              bit_src = '0;
      endcase
      case (sel)
         SEL_CTRL: bus_rdata = {{(BUS_W-2){1'b0}}, ctrl_q};
         SEL_PRIO: bus_rdata = prio_rd;
         SEL_TGT:  bus_rdata = tgt_rd;
         SEL_GROUP, SEL_SETEN, SEL_CLREN, SEL_SETPD, SEL_CLRPD:
                   bus_rdata = bit_src[{waddr[4:0], 5'b0} +: BUS_W];
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
   parameter int NUM_IRQ = 64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [11:0]            bus_addr,
   input logic [31:0]            bus_wdata,
   input logic [3:0]             bus_strb,
   input logic [31:0]            bus_rdata,
   input logic [NUM_IRQ-1:0]     irq_in,
   input logic [NUM_IRQ-1:0]     en_o,
   input logic [NUM_IRQ-1:0]     pend_o,
   input logic [NUM_IRQ-1:0]     grp_o,
   input logic [NUM_IRQ*8-1:0]   prio_o,
   input logic                   grp0_en_o
);
   p_set_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[11:2] == 10'h040 && bus_strb[0] && bus_wdata[0]) |=> en_o[0]);

   p_clr_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[11:2] == 10'h060 && bus_strb[0] && bus_wdata[0]) |=> !en_o[0]);

   p_edge_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[0] && !$past(irq_in[0])) |=> pend_o[0]);

   p_prio_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[11:2] == 10'h100 && bus_strb[0]) |=> prio_o[7:0] == $past(bus_wdata[7:0]));

   p_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[11:2] == 10'h000 && bus_strb[0]) |=> grp0_en_o == $past(bus_wdata[0]));

   p_unmapped_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[11:10] == 2'b11) |-> bus_rdata == 32'h0);

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(en_o) && $stable(grp_o)));
endmodule

bind irq_dist_regs irq_dist_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
   .irq_in(irq_in), .en_o(en_o), .pend_o(pend_o), .grp_o(grp_o),
   .prio_o(prio_o), .grp0_en_o(grp0_en_o));

// File: tb/sim_irq_dist_regs.sv
`timescale 1ns/1ps
module sim_irq_dist_regs;
   localparam int NI = 40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [3:0]      bus_strb = '0;
   logic [31:0]     bus_rdata;
   logic [NI-1:0]   irq_in = '0;
   logic [NI-1:0]   en_o, pend_o, grp_o;
   logic [NI*8-1:0] prio_o, tgt_o;
   logic            grp0_en_o, grp1_en_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_dist_regs #(.NUM_IRQ(NI)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .en_o(en_o), .pend_o(pend_o), .grp_o(grp_o),
      .prio_o(prio_o), .tgt_o(tgt_o), .grp0_en_o(grp0_en_o), .grp1_en_o(grp1_en_o));

   typedef struct packed {
      logic [11:0] waddr;
      logic [31:0] wdata;
      logic [3:0]  strb;
      logic [11:0] raddr;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{12'h100, 32'h0000_00F0, 4'hF, 12'h100, 32'h0000_00F0}, // R2 set
      '{12'h100, 32'h0000_000F, 4'hF, 12'h180, 32'h0000_00FF}, // R2 alias read
      '{12'h180, 32'h0000_0011, 4'hF, 12'h100, 32'h0000_00EE}, // R3 clear
      '{12'h104, 32'hFFFF_FFFF, 4'hF, 12'h104, 32'h0000_00FF}, // R10 partial word
      '{12'h108, 32'hFFFF_FFFF, 4'hF, 12'h108, 32'h0000_0000}, // R10 absent word
      '{12'h080, 32'hA5A5_A5A5, 4'h5, 12'h080, 32'h00A5_00A5}, // R12 lanes, R4
      '{12'h100, 32'hFFFF_FFFF, 4'h0, 12'h100, 32'h0000_00EE}, // R12 no strobe
      '{12'h404, 32'h0000_3C00, 4'h2, 12'h404, 32'h0000_3C00}, // R7 one byte
      '{12'h404, 32'h1122_3344, 4'hF, 12'h404, 32'h1122_3344}, // R7 word
      '{12'h404, 32'hFFFF_FFFF, 4'h8, 12'h404, 32'hFF22_3344}, // R7 lane 3 only
      '{12'h808, 32'h0403_0201, 4'hF, 12'h808, 32'h0403_0201}, // R8 packed
      '{12'h808, 32'h0000_AA00, 4'h2, 12'h808, 32'h0403_AA01}, // R8 one target
      '{12'h424, 32'hFFFF_FFFF, 4'hF, 12'h424, 32'hFFFF_FFFF}, // R10 last lines
      '{12'h428, 32'hFFFF_FFFF, 4'hF, 12'h428, 32'h0000_0000}, // R10 past count
      '{12'h300, 32'hFFFF_FFFF, 4'hF, 12'h300, 32'h0000_0000}, // R11
      '{12'hC00, 32'hFFFF_FFFF, 4'hF, 12'hC00, 32'h0000_0000}, // R11
      '{12'h000, 32'h0000_0003, 4'hF, 12'h000, 32'h0000_0003}, // R9
      '{12'h000, 32'hFFFF_FFFD, 4'hF, 12'h000, 32'h0000_0001}, // R9 spare bits
      '{12'h200, 32'h0000_0300, 4'hF, 12'h280, 32'h0000_0300}, // R5 set
      '{12'h280, 32'h0000_0100, 4'hF, 12'h200, 32'h0000_0200}, // R5 clear
      '{12'h004, 32'hFFFF_FFFF, 4'hF, 12'h000, 32'h0000_0001}  // R11 write ignored
   };

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
      @(negedge clk);
      bus_wr = 1'b0; bus_strb = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(12'h100, rd); chk("R1 enable word", 64'(rd), 64'h0);
      bus_read(12'h404, rd); chk("R1 priority word", 64'(rd), 64'h0);
      bus_read(12'h000, rd); chk("R1 control", 64'(rd), 64'h0);
      chk("R1 pend/grp outputs", {24'h0, pend_o}, {24'h0, grp_o});
      chk("R1 prio/tgt outputs", 64'(prio_o | tgt_o), 64'h0);

      for (int k = 0; k < NV; k++) begin
         bus_write(TBL[k].waddr, TBL[k].wdata, TBL[k].strb);
         bus_read(TBL[k].raddr, rd);
         chk($sformatf("table row %0d (R2..R12)", k), 64'(rd), 64'(TBL[k].exp));
      end

      // output vectors after the table
      chk("R2 R3 en_o", 64'(en_o), 64'({8'hFF, 24'h0, 8'hEE}));
      chk("R4 grp_o", 64'(grp_o[15:0]), 64'h00A5);
      chk("R7 prio_o irq5", 64'(prio_o[47:40]), 64'h33);
      chk("R8 tgt_o irq9", 64'(tgt_o[79:72]), 64'hAA);
      chk("R9 group enables", {62'h0, grp1_en_o, grp0_en_o}, 64'h1);
      chk("R5 pend_o", 64'(pend_o), 64'h200);

      // R6 edge latching
      @(negedge clk);
      irq_in[20] = 1'b1;
      #1 chk("R6 before edge", 64'(pend_o[20]), 64'h0);
      @(negedge clk);
      chk("R6 after edge", 64'(pend_o[20]), 64'h1);
      bus_write(12'h280, 32'h0010_0000, 4'hF);
      repeat (2) @(negedge clk);
      chk("R6 held level no retrigger", 64'(pend_o[20]), 64'h0);

      // R6 edge beats same-cycle clear
      bus_write(12'h200, 32'h0020_0000, 4'hF);
      chk("R6 preset line 21", 64'(pend_o[21]), 64'h1);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h0020_0000; bus_strb = 4'hF;
      irq_in[21] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_strb = '0;
      chk("R6 edge wins over clear", 64'(pend_o[21]), 64'h1);

      finish_run();
   end
endmodule